// File: doc/BRIEF.md
# Programmable Clock Ratio Controller

This block sets the clock ratios of a group of eleven downstream clock domains. A multiplier stage reports how far the parent reference is scaled. Each of the eleven channels owns a 4-bit ratio code that picks a divisor from a fixed, non-power-of-two table. The block divides its own clock by that divisor and turns the result into a one-cycle rate-enable pulse for the channel. It also reports the divisor that is currently in force for every channel and the multiplier factor that is currently in force.

Software programs the block through a small register port with four word addresses. Ratio codes are written into shadow storage, and a read returns what was written. A channel's divisor changes only when software sets the commit bit, which clears itself. At commit, every channel whose shadow code is legal takes that code, and every channel's count restarts from zero, so all channels line up on one cycle. A shadow code that names a reserved table slot is flagged, and that channel keeps its old divisor through the commit.

Top module: `clkrat_ctrl`

## Requirements
- R1: Codes map to divisors as follows: 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 9→32, 10→36, 11→48, 13→72, 14→96. After a commit, the slice of `div_o` for a channel (bits 7*i+6 down to 7*i) shows the divisor for that channel's committed code.
- R2: Codes 12 and 15 are reserved. `err_o[i]` is 1 while channel i's shadow code is reserved. A commit leaves that channel's divisor unchanged.
- R3: A write changes only shadow codes. `div_o` holds its value until a commit. Reading a ratio word returns the shadow codes in their field positions, and all unused bits read as 0.
- R4: Writing address 1 with bit 31 set arms the commit. Between that write edge and the next edge, reading address 1 shows bit 31 as 1. At the next edge the commit takes effect, and from then on bit 31 reads as 0.
- R5: Code field positions (4 bits each) are as follows. Address 0 holds channels 0..3 at bit offsets 20, 16, 8, 4. Address 1 holds channel 4 at offset 4. Address 2 holds channels 5..10 at offsets 20, 16, 12, 8, 4, 0.
- R6: `mult_o` equals bits 30:24 of address 0 plus one when bit 14 of address 3 is set, and 1 otherwise. Both fields read back at their positions. The multiplier takes effect without a commit.
- R7: `ch_en_o[i]` is high for exactly one cycle in every D cycles, where D is channel i's divisor.
- R8: After a commit edge every channel count restarts at zero. `ch_en_o[i]` is first high D-1 cycles after the commit edge, and every D cycles after that.
- R9: After reset every shadow and active code is 0 (divisor 2), `mult_o` is 1, `err_o` is 0, and every address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address (0 ratio A, 1 ratio B + commit, 2 ratio C, 3 PLL config) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| ch_en_o | output | 11 | Per-channel rate-enable pulse |
| div_o | output | 77 | Active divisor per channel, 7 bits each |
| mult_o | output | 8 | Effective multiplier factor, 1..128 |
| err_o | output | 11 | Shadow code of channel is reserved |

## Verification
A corrupted shadow code shows at once on the read port and on `err_o`, before any commit. A wrong active code shows on that channel's `div_o` slice from the cycle after the commit edge. A counter that fails to restart, or that wraps at the wrong count, shows as an enable pulse in the wrong cycle within at most one divisor period after the commit. The period tests therefore sample every cycle, starting at the commit edge. A commit bit that does not clear itself shows at the next read of address 1.

// File: rtl/clkrat_pkg.sv
package clkrat_pkg;
  localparam int NCH      = 11;
  localparam int CODE_W   = 4;
  localparam int DIV_W    = 7;
  localparam int MULT_FW  = 7;
  localparam int MULT_W   = MULT_FW + 1;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int KICK_BIT = 31;
  localparam int PLL_BIT  = 14;
  localparam int MULT_LSB = 24;
  localparam logic [15:0] CODE_OK = 16'h6FFF;

  localparam logic [ADDR_W-1:0] A_RATIO_A = 2'd0;
  localparam logic [ADDR_W-1:0] A_RATIO_B = 2'd1;
  localparam logic [ADDR_W-1:0] A_RATIO_C = 2'd2;
  localparam logic [ADDR_W-1:0] A_PLL     = 2'd3;

  function automatic logic [ADDR_W-1:0] ch_reg(input int ch);
    if (ch < 4)       return A_RATIO_A;
    else if (ch == 4) return A_RATIO_B;
    else              return A_RATIO_C;
  endfunction

  function automatic int ch_off(input int ch);
    case (ch)
      0: return 20;  1: return 16;  2: return 8;   3: return 4;
      4: return 4;
      5: return 20;  6: return 16;  7: return 12;  8: return 8;
      9: return 4;   default: return 0;
    endcase
  endfunction

  // reserved slots return 0
  function automatic logic [DIV_W-1:0] code_div(input logic [CODE_W-1:0] c);
    case (c)
      4'd0:  return 7'd2;   4'd1:  return 7'd3;   4'd2:  return 7'd4;
      4'd3:  return 7'd6;   4'd4:  return 7'd8;   4'd5:  return 7'd12;
      4'd6:  return 7'd16;  4'd7:  return 7'd18;  4'd8:  return 7'd24;
      4'd9:  return 7'd32;  4'd10: return 7'd36;  4'd11: return 7'd48;
      4'd13: return 7'd72;  4'd14: return 7'd96;
      default: return 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/clkrat_regs.sv
module clkrat_regs
  import clkrat_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [NCH*CODE_W-1:0]   shadow_o,
  output logic [MULT_FW-1:0]      mult_fld_o,
  output logic                    pll_en_o,
  output logic                    kick_o,
  output logic [DATA_W-1:0]       rdata_o
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_shadow
    localparam int OFF = ch_off(ch);
    localparam logic [ADDR_W-1:0] REG = ch_reg(ch);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        shadow_o[ch*CODE_W +: CODE_W] <= '0;
      else if (wr_i && addr_i == REG)
        shadow_o[ch*CODE_W +: CODE_W] <= wdata_i[OFF +: CODE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_fld_o <= '0;
      pll_en_o   <= 1'b0;
      kick_o     <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_RATIO_A) mult_fld_o <= wdata_i[MULT_LSB +: MULT_FW];
      if (wr_i && addr_i == A_PLL)     pll_en_o   <= wdata_i[PLL_BIT];
      // single-cycle pulse: self-clears at the commit edge
      kick_o <= wr_i && addr_i == A_RATIO_B && wdata_i[KICK_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (addr_i == ch_reg(i)) rdata_o[ch_off(i) +: CODE_W] = shadow_o[i*CODE_W +: CODE_W];
    case (addr_i)
      A_RATIO_A: rdata_o[MULT_LSB +: MULT_FW] = mult_fld_o;
      A_RATIO_B: rdata_o[KICK_BIT]            = kick_o;
      A_PLL:     rdata_o[PLL_BIT]             = pll_en_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/clkrat_chan.sv
module clkrat_chan
  import clkrat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o,
  output logic [DIV_W-1:0]  div_o
);
  logic [CODE_W-1:0] act_q;
  logic [DIV_W-1:0]  cnt_q;
  logic              last;

  assign div_o = code_div(act_q);
  assign last  = cnt_q == div_o - DIV_W'(1);
  assign en_o  = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (commit_i) begin
      if (CODE_OK[code_i]) act_q <= code_i;
      cnt_q <= '0;
    end else if (last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/clkrat_ctrl.sv
module clkrat_ctrl
  import clkrat_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NCH-1:0]        ch_en_o,
  output logic [NCH*DIV_W-1:0]  div_o,
  output logic [MULT_W-1:0]     mult_o,
  output logic [NCH-1:0]        err_o
);
  logic [NCH*CODE_W-1:0] shadow;
  logic [MULT_FW-1:0]    mult_fld;
  logic                  pll_en;
  logic                  commit;

  clkrat_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .shadow_o   (shadow),
    .mult_fld_o (mult_fld),
    .pll_en_o   (pll_en),
    .kick_o     (commit),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    clkrat_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .commit_i (commit),
      .code_i   (shadow[ch*CODE_W +: CODE_W]),
      .en_o     (ch_en_o[ch]),
      .div_o    (div_o[ch*DIV_W +: DIV_W])
    );
    assign err_o[ch] = !CODE_OK[shadow[ch*CODE_W +: CODE_W]];
  end

  assign mult_o = pll_en ? {1'b0, mult_fld} + MULT_W'(1) : MULT_W'(1);
endmodule

// File: rtl/clkrat_chk.sv
module clkrat_chk
  import clkrat_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 commit,
  input logic                 pll_en,
  input logic [NCH-1:0]       ch_en_o,
  input logic [NCH*DIV_W-1:0] div_o,
  input logic [MULT_W-1:0]    mult_o,
  input logic [NCH-1:0]       err_o
);
  AST_KICK_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !commit); // R4

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(div_o)); // R3

  AST_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> ch_en_o == '0); // R8

  AST_MULT_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en |-> mult_o == MULT_W'(1)); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_ERR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit && err_o[i]) |=> $stable(div_o[i*DIV_W +: DIV_W])); // R2

    AST_DIV_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_o[i*DIV_W +: DIV_W] >= DIV_W'(2)); // R1
  end
endmodule

bind clkrat_ctrl clkrat_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .commit  (commit),
  .pll_en  (pll_en),
  .ch_en_o (ch_en_o),
  .div_o   (div_o),
  .mult_o  (mult_o),
  .err_o   (err_o)
);

// File: tb/tb_clkrat_ctrl.sv
`timescale 1ns/1ps
module tb_clkrat_ctrl;
  localparam int NCH = 11;
  localparam int DW  = 7;
  localparam logic [31:0] KICK = 32'h8000_0000;
  // code, expected divisor, expected err; reserved codes keep the prior divisor
  localparam logic [11:0] VEC [16] = '{
    {4'd0, 7'd2, 1'b0},  {4'd1, 7'd3, 1'b0},  {4'd2, 7'd4, 1'b0},  {4'd3, 7'd6, 1'b0},
    {4'd4, 7'd8, 1'b0},  {4'd5, 7'd12, 1'b0}, {4'd6, 7'd16, 1'b0}, {4'd7, 7'd18, 1'b0},
    {4'd8, 7'd24, 1'b0}, {4'd9, 7'd32, 1'b0}, {4'd10, 7'd36, 1'b0},{4'd11, 7'd48, 1'b0},
    {4'd12, 7'd48, 1'b1},{4'd13, 7'd72, 1'b0},{4'd14, 7'd96, 1'b0},{4'd15, 7'd96, 1'b1}};
  localparam int OFFS [NCH] = '{20, 16, 8, 4, 4, 20, 16, 12, 8, 4, 0};
  localparam int REGS [NCH] = '{0, 0, 0, 0, 1, 2, 2, 2, 2, 2, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] ch_en, err;
  logic [NCH*DW-1:0] div;
  logic [7:0] mult;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  clkrat_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ch_en_o(ch_en),
    .div_o(div), .mult_o(mult), .err_o(err));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  function automatic int dsel(input int ch);
    return int'(div[ch*DW +: DW]);
  endfunction

  // build the three ratio words from per-channel codes
  function automatic logic [31:0] word(input int r, input int codes [NCH]);
    logic [31:0] w = '0;
    for (int i = 0; i < NCH; i++)
      if (REGS[i] == r) w[OFFS[i] +: 4] = 4'(codes[i]);
    return w;
  endfunction

  task automatic commit_all(input int codes [NCH]);
    wreg(2'd0, word(0, codes));
    wreg(2'd2, word(2, codes));
    wreg(2'd1, word(1, codes) | KICK);
    @(negedge clk);
  endtask

  task automatic period_check(input int exp_div [NCH], input string req);
    int bad [NCH];
    for (int i = 0; i < NCH; i++) bad[i] = 0;
    for (int j = 0; j < 200; j++) begin
      for (int i = 0; i < NCH; i++)
        if (ch_en[i] != ((j % exp_div[i]) == exp_div[i] - 1)) bad[i]++;
      @(negedge clk);
    end
    for (int i = 0; i < NCH; i++) check(bad[i] == 0, req, bad[i], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int codes [NCH];
    int exp_div [NCH];
    int ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    for (int i = 0; i < NCH; i++) check(dsel(i) == 2, "R9 div", dsel(i), 2);
    check(mult == 8'd1, "R9 mult", mult, 1);
    check(err == '0, "R9 err", err, 0);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #1 check(rdata == 32'd0, "R9 rdata", rdata, 0);
    end

    // R1 R2: walk the code table on every channel
    for (int v = 0; v < 16; v++) begin
      for (int i = 0; i < NCH; i++) codes[i] = int'(VEC[v][11:8]);
      commit_all(codes);
      ok = 1;
      for (int i = 0; i < NCH; i++) if (dsel(i) != int'(VEC[v][7:1])) ok = 0;
      check(ok == 1, "R1 table div", dsel(0), VEC[v][7:1]);
      check(err == {NCH{VEC[v][0]}}, "R2 err flag", err, {NCH{VEC[v][0]}});
    end

    // R5 R7 R8: distinct code per channel, then per-cycle enable pattern
    for (int i = 0; i < NCH; i++) codes[i] = i;
    wreg(2'd0, word(0, codes));
    wreg(2'd2, word(2, codes));
    wreg(2'd1, word(1, codes) | KICK);
    // R4: commit bit visible for one cycle, then cleared
    addr = 2'd1;
    #1 check(rdata[31] == 1'b1, "R4 kick set", rdata[31], 1);
    @(negedge clk);
    check(rdata[31] == 1'b0, "R4 kick clear", rdata[31], 0);
    for (int i = 0; i < NCH; i++) begin
      exp_div[i] = int'(VEC[i][7:1]);
      check(dsel(i) == exp_div[i], "R5 field position", dsel(i), exp_div[i]);
    end
    period_check(exp_div, "R8 R7 enable phase");

    // R3: shadow write does not change active divisor, read returns shadow
    codes[0] = 4;
    wreg(2'd0, word(0, codes));
    addr = 2'd0;
    #1 check(rdata == word(0, codes), "R3 readback", rdata, word(0, codes));
    repeat (5) @(negedge clk);
    check(dsel(0) == 2, "R3 hold before kick", dsel(0), 2);
    wreg(2'd1, word(1, codes) | KICK);
    @(negedge clk);
    check(dsel(0) == 8, "R3 after kick", dsel(0), 8);
    exp_div[0] = 8;
    period_check(exp_div, "R8 realign after recommit");

    // R2: reserved shadow codes on one channel
    codes[5] = 12;
    wreg(2'd2, word(2, codes));
    check(err == 11'b000_0010_0000, "R2 err on write", err, 11'b000_0010_0000);
    wreg(2'd1, word(1, codes) | KICK);
    @(negedge clk);
    check(dsel(5) == 12, "R2 keep divisor", dsel(5), 12);
    codes[5] = 15;
    wreg(2'd2, word(2, codes));
    wreg(2'd1, word(1, codes) | KICK);
    @(negedge clk);
    check(dsel(5) == 12 && err[5], "R2 keep on 15", dsel(5), 12);
    codes[5] = 13;
    wreg(2'd2, word(2, codes));
    check(err == '0, "R2 err clears", err, 0);
    wreg(2'd1, word(1, codes) | KICK);
    @(negedge clk);
    check(dsel(5) == 72, "R2 valid after reserved", dsel(5), 72);

    // R6: multiplier
    wreg(2'd0, word(0, codes) | (32'd127 << 24));
    check(mult == 8'd1, "R6 bypass", mult, 1);
    addr = 2'd0;
    #1 check(rdata[30:24] == 7'd127, "R6 field readback", rdata[30:24], 127);
    wreg(2'd3, 32'h0000_4000);
    check(mult == 8'd128, "R6 max", mult, 128);
    addr = 2'd3;
    #1 check(rdata == 32'h0000_4000, "R6 enable readback", rdata, 32'h4000);
    wreg(2'd0, word(0, codes) | (32'd4 << 24));
    check(mult == 8'd5, "R6 factor", mult, 5);
    check(dsel(0) == 8, "R6 no divider change", dsel(0), 8);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule